// File: doc/BRIEF.md
# Fractional Clock Divider with Gated Output

The block derives a slower clock from a reference clock by a fractional ratio M/N with M no larger than N. A single 32-bit control word holds the output enable, the numerator, the denominator and an apply request. Inside the block a phase accumulator adds M on every reference cycle. Each time the sum reaches N, the accumulator takes N away and lets exactly one full reference pulse through to the output. Over any N consecutive reference cycles the output therefore carries exactly M pulses. With M equal to N the reference passes straight through.

Software writes the control word through a plain write/read port. A new M/N pair stays parked in the control word until the apply bit is written as 1. The block then moves the ratio into the accumulator at the next wrap, restarts the phase from zero and clears the apply bit itself. A write of an all-zero word is replaced by a 1/1 default, so the block can never divide by zero. Zero fields and ratios above one in the active divider fall back to pass-through. The output enable acts at once. The output pulse enable is latched while the reference is low, so a pulse is never cut short.

Top module: `frac_clk_div`

## Requirements
- R1: After reset, rd_data reads 32'h0001_0002 (bit 0 enable = 0, bits 15:1 M = 1, bits 30:16 N = 1, bit 31 apply = 0) and clk_out stays low.
- R2: A write of a non-zero word with bit 31 = 0 reads back unchanged on rd_data in the cycle after the write.
- R3: A write of 32'h0000_0000 stores 32'h0001_0002 instead.
- R4: Writing bit 31 = 1 keeps bit 31 reading 1 until the ratio has been loaded at an accumulator wrap, and then the hardware clears it. New M/N fields written with bit 31 = 0 leave the running ratio unchanged.
- R5: With enable = 1 and a legal active ratio (1 <= M <= N), any window of k*N reference cycles holds exactly k*M rising edges on clk_out.
- R6: With enable (bit 0) = 0, clk_out shows no rising edge.
- R7: If the applied M or N is zero, or M > N, the divider runs at ratio 1: one clk_out pulse per reference cycle.
- R8: clk_out is never high while ref_clk is low, so each output pulse is one reference high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Current control word |
| clk_out | output | 1 | Divided, gated clock |

## Verification
The bench counts output edges over windows that are whole multiples of N. An accumulator that drops or doubles a carry, or one that loses the remainder after subtracting N, therefore shows up as a count that is off by at least one. It writes new fields without the apply bit. A divider that applied them at once would change its rate. Apply bits that never clear, or that clear before the wrap, are caught by polling rd_data. Zero words, zero fields and M > N are driven directly. A missing default would stall the output or divide by zero, and an unchecked M > N would produce the wrong rate. Gating off must silence the output entirely.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    localparam int FCD_FW       = 15;
    localparam int FCD_M_LSB    = 1;
    localparam int FCD_N_LSB    = 16;
    localparam int FCD_GATE_BIT = 0;
    localparam int FCD_APPLY_BIT = 31;
    localparam logic [31:0] FCD_SAFE_WORD = 32'h0001_0002;

    typedef logic [FCD_FW-1:0] fcd_field_t;

    typedef struct packed {
        fcd_field_t m;
        fcd_field_t n;
    } fcd_ratio_t;

    typedef struct packed {
        fcd_field_t acc;
        fcd_field_t m;
        fcd_field_t n;
        logic       pulse;
    } fcd_acc_st_t;

    function automatic fcd_field_t fcd_get_m(input logic [31:0] w);
        return w[FCD_M_LSB +: FCD_FW];
    endfunction

    function automatic fcd_field_t fcd_get_n(input logic [31:0] w);
        return w[FCD_N_LSB +: FCD_FW];
    endfunction

    function automatic fcd_ratio_t fcd_legalize(input fcd_field_t m, input fcd_field_t n);
        fcd_ratio_t r;
        if ((m == '0) || (n == '0) || (m > n)) begin
            r.m = fcd_field_t'(1);
            r.n = fcd_field_t'(1);
        end else begin
            r.m = m;
            r.n = n;
        end
        return r;
    endfunction

endpackage

// File: rtl/fcd_cfg_reg.sv
module fcd_cfg_reg
    import fcd_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          load_i,
    output logic [DW-1:0] cfg_o
);

    logic [DW-1:0] cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            if (wr_data == '0) begin
                cfg_d = DW'(FCD_SAFE_WORD);
            end else begin
                cfg_d = wr_data;
            end
        end else if (load_i) begin
            cfg_d[FCD_APPLY_BIT] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= DW'(FCD_SAFE_WORD);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;

    AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q != '0); // R3

    AST_APPLY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[FCD_APPLY_BIT] && !wr_en && !load_i) |=> cfg_q[FCD_APPLY_BIT]); // R4

endmodule

// File: rtl/fcd_phase_acc.sv
module fcd_phase_acc
    import fcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  fcd_field_t new_m_i,
    input  fcd_field_t new_n_i,
    input  logic       apply_i,
    output logic       load_o,
    output logic       pulse_o
);

    localparam int SW = FCD_FW + 1;

    fcd_acc_st_t st_d, st_q;
    logic [SW-1:0] sum;
    logic          wrap;
    fcd_ratio_t    fixed;

    always_comb begin
        st_d  = st_q;
        sum   = {1'b0, st_q.acc} + {1'b0, st_q.m};
        wrap  = (sum >= {1'b0, st_q.n});
        fixed = fcd_legalize(new_m_i, new_n_i);
        load_o = apply_i && wrap;
        st_d.pulse = wrap;
        if (wrap) begin
            st_d.acc = fcd_field_t'(sum - {1'b0, st_q.n});
        end else begin
            st_d.acc = fcd_field_t'(sum);
        end
        if (load_o) begin
            st_d.acc = '0;
            st_d.m   = fixed.m;
            st_d.n   = fixed.n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.acc   <= '0;
            st_q.m     <= fcd_field_t'(1);
            st_q.n     <= fcd_field_t'(1);
            st_q.pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o = st_q.pulse;

    AST_ACC_BELOW_N: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.acc < st_q.n); // R5

    AST_RATIO_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.m != '0) && (st_q.n != '0) && (st_q.m <= st_q.n)); // R7

endmodule

// File: rtl/fcd_out_gate.sv
module fcd_out_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_i,
    input  logic pulse_i,
    output logic clk_out
);

    logic en_d, en_q;

    always_comb begin
        en_d = gate_i & pulse_i;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= en_d;
        end
    end

    assign clk_out = clk & en_q;

    AST_GATED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_i |-> !en_q); // R6

endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
    import fcd_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          ref_clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic          clk_out
);

    logic [DW-1:0] cfg;
    logic          load;
    logic          pulse;

    fcd_cfg_reg #(.DW(DW)) u_cfg (
        .clk     (ref_clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .load_i  (load),
        .cfg_o   (cfg)
    );

    fcd_phase_acc u_acc (
        .clk     (ref_clk),
        .rst_n   (rst_n),
        .new_m_i (fcd_get_m(32'(cfg))),
        .new_n_i (fcd_get_n(32'(cfg))),
        .apply_i (cfg[FCD_APPLY_BIT]),
        .load_o  (load),
        .pulse_o (pulse)
    );

    fcd_out_gate u_gate (
        .clk     (ref_clk),
        .rst_n   (rst_n),
        .gate_i  (cfg[FCD_GATE_BIT]),
        .pulse_i (pulse),
        .clk_out (clk_out)
    );

    assign rd_data = cfg;

endmodule

// File: tb/tb_frac_clk_div.sv
module tb_frac_clk_div;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        clk_out;

    int checks = 0;
    int fails  = 0;
    int edges  = 0;
    int glitch = 0;

    frac_clk_div dut (
        .ref_clk (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .clk_out (clk_out)
    );

    always #4 clk = ~clk;

    always @(posedge clk_out) edges++;
    always @(clk_out or clk) begin
        #0;
        if (clk_out && !clk) glitch++;
    end

    initial begin
        #(8 * 190000);
        fails++;
        checks++;
        $display("FAIL R5 watchdog expired: actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mkword(input int m, input int n, input bit gate, input bit apply);
        return {apply, n[14:0], m[14:0], gate};
    endfunction

    function automatic int eff_m(input int m, input int n);
        return (m == 0 || n == 0 || m > n) ? 1 : m;
    endfunction

    function automatic int eff_n(input int m, input int n);
        return (m == 0 || n == 0 || m > n) ? 1 : n;
    endfunction

    task automatic wr(input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_applied(input string req);
        int t = 0;
        while (rd_data[31] && t < 70000) begin
            @(negedge clk);
            t++;
        end
        chk(req, int'(rd_data[31]), 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic measure(input int cycles, output int cnt);
        int s;
        @(negedge clk);
        s = edges;
        repeat (cycles) @(negedge clk);
        cnt = edges - s;
    endtask

    task automatic rate_case(input int m, input int n, input string req);
        int c;
        int em = eff_m(m, n);
        int en = eff_n(m, n);
        wr(mkword(m, n, 1'b1, 1'b1));
        wait_applied("R4");
        measure(4 * en, c);
        chk(req, c, 4 * em);
    endtask

    initial begin
        int c;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", int'(rd_data), 32'h0001_0002);
        measure(20, c);
        chk("R1", c, 0);

        // R2 readback without apply
        wr(mkword(3, 7, 1'b0, 1'b0));
        chk("R2", int'(rd_data), int'(mkword(3, 7, 1'b0, 1'b0)));

        // R3 all-zero write
        wr(32'h0);
        chk("R3", int'(rd_data), 32'h0001_0002);

        // R6 gate off while ratio runs
        wr(mkword(2, 5, 1'b0, 1'b1));
        wait_applied("R4");
        measure(40, c);
        chk("R6", c, 0);

        // R5 directed rates
        rate_case(1, 1, "R5");
        rate_case(3, 8, "R5");
        rate_case(1, 37, "R5");
        rate_case(29, 30, "R5");

        // R4 fields without apply keep the running ratio 29/30
        wr(mkword(1, 4, 1'b1, 1'b0));
        chk("R2", int'(rd_data), int'(mkword(1, 4, 1'b1, 1'b0)));
        measure(120, c);
        chk("R4", c, 116);
        // apply now takes 1/4
        wr(mkword(1, 4, 1'b1, 1'b1));
        wait_applied("R4");
        measure(40, c);
        chk("R4", c, 10);

        // R7 illegal settings
        rate_case(9, 4, "R7");
        rate_case(0, 6, "R7");
        rate_case(5, 0, "R7");

        // R5 random ratios
        for (int i = 0; i < 12; i++) begin
            int n = 1 + int'($urandom % 60);
            int m = 1 + int'($urandom % n);
            rate_case(m, n, "R5");
        end

        // R6 gate off after running
        wr(mkword(5, 9, 1'b0, 1'b0));
        repeat (2) @(negedge clk);
        measure(36, c);
        chk("R6", c, 0);

        // R8 no output high during low reference phase
        chk("R8", glitch, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule